// File: doc/BRIEF.md
# RMII Receive Data Interface

This block sits between the receive side of a 100 Mb/s physical coding sublayer and the RMII receive pins. The PCS side hands over decoded 4-bit nibbles, each qualified by a valid strobe, together with a carrier indication and a false-carrier flag. On the reference clock the block drives a combined carrier-sense/data-valid signal and a 2-bit receive data bus. A small FIFO, sized by a parameter, takes up the slack between the rate at which nibbles arrive and the rate at which dibits leave.

Data is held back until the FIFO has filled to half its depth. From then on one dibit leaves on every reference clock. When carrier goes away while nibbles are still queued, the combined signal switches to half-rate toggling that is aligned to nibble boundaries until the queue is empty. A false carrier shows up as a fixed code on the data pins for the rest of the event. FIFO overflow and underflow are reported on a sticky error output.

Top module: `rmii_rx_if`

## Requirements
- R1: After reset, and whenever no receive event is active and no data is queued, the combined signal is low, the receive dibit is 00 and the error output is low.
- R2: When carrier rises from idle, the combined signal goes high in the same cycle, without waiting for a clock edge.
- R3: While the FIFO holds fewer than DEPTH/2 nibbles after carrier rises, the combined signal stays high and the dibit stays 00. The clock edge that sees at least DEPTH/2 nibbles starts the output, and the first data dibit appears in the cycle after that edge.
- R4: Each nibble leaves as two consecutive dibits, bits 1:0 first and then bits 3:2. One dibit is sent per clock, and nibbles leave in arrival order.
- R5: When carrier drops with data still queued, the combined signal stays high until the current nibble is complete. It is then low on the first dibit and high on the second dibit of each remaining nibble. After the last dibit the block returns to idle.
- R6: When a false carrier is flagged at the start of an event, the dibit is 10 and the combined signal is high from the next cycle until carrier drops. Nibbles that arrive meanwhile are discarded and never appear in a later frame.
- R7: Nibble strobes that arrive while carrier is low are ignored and leave no data in the FIFO.
- R8: A nibble that arrives while the FIFO is full is dropped and sets the error output.
- R9: If the FIFO runs empty while output is running and carrier is still high, the error output is set and the dibit is 00. The error output stays set until the next carrier event begins, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcsCarrier | input | 1 | Carrier indication from the PCS |
| pcsFalseCarrier | input | 1 | False-carrier flag from the PCS, meaningful at the start of an event |
| nibValid | input | 1 | Strobe qualifying nibData |
| nibData | input | 4 | Decoded receive nibble |
| rmiiCrsDv | output | 1 | Combined carrier-sense/data-valid |
| rmiiRxd | output | 2 | Receive dibit |
| rxError | output | 1 | Sticky FIFO overflow/underflow flag |

## Verification
The hardest situation to reach is the drain phase. It depends on the exact parity between the dibit phase and the clock edge at which carrier falls. Each frame task therefore schedules nibbles on a fixed two-cycle cadence and drops carrier either on the nibble boundary or one clock later, so both alignments of the toggling start are covered. Underflow needs the FIFO to empty while carrier is still up. To get there, the stimulus delivers exactly half a FIFO of nibbles back to back and then stops the strobe while carrier stays high.

// File: rtl/rmii_rx_pkg.sv
`timescale 1ns/1ps
package rmii_rx_pkg;

  localparam int NIB_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_STREAM,
    ST_DRAIN,
    ST_FALSE
  } rxState_e;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_DATA,
    SEL_FALSE
  } rxdSel_e;

  typedef struct packed {
    logic    wrEn;
    logic    pop;
    logic    flush;
    logic    dibitHi;
    rxdSel_e sel;
  } rxStrobe_t;

endpackage

// File: rtl/rmii_rx_fifo.sv
`timescale 1ns/1ps
module rmii_rx_fifo
  import rmii_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxStrobe_t                    stb,
  input  logic [NIB_W-1:0]             nibData,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full,
  output logic [1:0]                   rxd
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [NIB_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [CW-1:0]    cnt;
  logic [NIB_W-1:0] head;

  function automatic logic [AW-1:0] ptrNext(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wrEn && !stb.flush) mem[wrPtr] <= nibData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (stb.wrEn) wrPtr <= ptrNext(wrPtr);
      if (stb.pop)  rdPtr <= ptrNext(rdPtr);
      case ({stb.wrEn, stb.pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign count = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rdPtr];

  always_comb begin
    unique case (stb.sel)
      SEL_DATA:  rxd = empty ? 2'b00 : (stb.dibitHi ? head[3:2] : head[1:0]);
      SEL_FALSE: rxd = 2'b10;
      default:   rxd = 2'b00;
    endcase
  end

  // R9: the control never pops an empty queue
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !empty);

  // R8: a write is never issued into a full queue
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> !full);

  // R8: occupancy stays within the depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/rmii_rx_ctrl.sv
`timescale 1ns/1ps
module rmii_rx_ctrl
  import rmii_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pcsCarrier,
  input  logic                         pcsFalseCarrier,
  input  logic                         nibValid,
  input  logic [$clog2(DEPTH+1)-1:0]   count,
  input  logic                         empty,
  input  logic                         full,
  output rxStrobe_t                    stb,
  output logic                         rmiiCrsDv,
  output logic                         rxError
);

  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  rxState_e stateQ, stateD;
  logic     phaseQ, phaseD;
  logic     errQ, errD;
  logic     stIdle, stFill, stStream, stDrain, stFalse;
  logic     accept, pop, lastPop, overflowHit, underflowHit, active;

  assign stIdle   = (stateQ == ST_IDLE);
  assign stFill   = (stateQ == ST_FILL);
  assign stStream = (stateQ == ST_STREAM);
  assign stDrain  = (stateQ == ST_DRAIN);
  assign stFalse  = (stateQ == ST_FALSE);
  assign active   = stStream || stDrain;

  // nibbles are taken only during a genuine event that is still filling or streaming
  assign accept = nibValid && pcsCarrier &&
                  ((stIdle || stFill) ? !pcsFalseCarrier : stStream);
  assign overflowHit  = accept && full;
  assign pop          = active && phaseQ && !empty;
  assign lastPop      = pop && (count == CW'(1));
  assign underflowHit = stStream && pcsCarrier && empty;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (pcsCarrier) stateD = pcsFalseCarrier ? ST_FALSE : ST_FILL;
      ST_FILL: begin
        if (!pcsCarrier)               stateD = empty ? ST_IDLE : ST_DRAIN;
        else if (pcsFalseCarrier)      stateD = ST_FALSE;
        else if (count >= CW'(HALF))   stateD = ST_STREAM;
      end
      ST_STREAM: if (!pcsCarrier) stateD = (empty || lastPop) ? ST_IDLE : ST_DRAIN;
      ST_DRAIN:  if (empty || lastPop) stateD = ST_IDLE;
      ST_FALSE:  if (!pcsCarrier) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    if (stateD == ST_STREAM || stateD == ST_DRAIN)
      phaseD = (active && !empty) ? ~phaseQ : phaseQ;
    else
      phaseD = 1'b0;
  end

  always_comb begin
    errD = errQ;
    if (stIdle && pcsCarrier)          errD = 1'b0;
    if (overflowHit || underflowHit)   errD = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
      errQ   <= errD;
    end
  end

  always_comb begin
    stb.wrEn    = accept && !full;
    stb.pop     = pop;
    stb.flush   = stFalse;
    stb.dibitHi = phaseQ;
    if (stFalse)     stb.sel = SEL_FALSE;
    else if (active) stb.sel = SEL_DATA;
    else             stb.sel = SEL_ZERO;
  end

  always_comb begin
    unique case (stateQ)
      ST_IDLE:  rmiiCrsDv = pcsCarrier;
      ST_DRAIN: rmiiCrsDv = phaseQ;
      default:  rmiiCrsDv = 1'b1;
    endcase
  end

  assign rxError = errQ;

  // R2: carrier rising from idle is reflected at once
  assert_async_crs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stIdle && pcsCarrier) |-> rmiiCrsDv);

  // R3: output starts only once the queue reached half depth
  assert_start_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stStream) |-> ($past(count) >= CW'(HALF)));

  // R5: the combined signal alternates every cycle while draining
  assert_drain_toggle_R5: assert property (@(posedge clk) disable iff (!rstN)
    stDrain |=> (!stDrain || (rmiiCrsDv != $past(rmiiCrsDv))));

  // R7: no write without carrier
  assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pcsCarrier |-> !stb.wrEn);

endmodule

// File: rtl/rmii_rx_if.sv
`timescale 1ns/1ps
module rmii_rx_if
  import rmii_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pcsCarrier,
  input  logic       pcsFalseCarrier,
  input  logic       nibValid,
  input  logic [3:0] nibData,
  output logic       rmiiCrsDv,
  output logic [1:0] rmiiRxd,
  output logic       rxError
);

  localparam int CW = $clog2(DEPTH + 1);

  rxStrobe_t      ctrlStb;
  logic [CW-1:0]  fifoCount;
  logic           fifoEmpty;
  logic           fifoFull;

  rmii_rx_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk             (clk),
    .rstN            (rstN),
    .pcsCarrier      (pcsCarrier),
    .pcsFalseCarrier (pcsFalseCarrier),
    .nibValid        (nibValid),
    .count           (fifoCount),
    .empty           (fifoEmpty),
    .full            (fifoFull),
    .stb             (ctrlStb),
    .rmiiCrsDv       (rmiiCrsDv),
    .rxError         (rxError)
  );

  rmii_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (ctrlStb),
    .nibData (nibData),
    .count   (fifoCount),
    .empty   (fifoEmpty),
    .full    (fifoFull),
    .rxd     (rmiiRxd)
  );

  // R6: while the false-carrier flush runs, the pins carry the 10 code
  assert_false_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.flush |-> (rmiiRxd == 2'b10));

endmodule

// File: tb/rmii_rx_if_tb_top.sv
`timescale 1ns/1ps
module rmii_rx_if_tb_top;

  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pcsCarrier;
  logic       pcsFalseCarrier;
  logic       nibValid;
  logic [3:0] nibData;
  logic       rmiiCrsDv;
  logic [1:0] rmiiRxd;
  logic       rxError;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  rmii_rx_if #(.DEPTH(DEPTH)) dut_i (
    .clk             (clk),
    .rstN            (rstN),
    .pcsCarrier      (pcsCarrier),
    .pcsFalseCarrier (pcsFalseCarrier),
    .nibValid        (nibValid),
    .nibData         (nibData),
    .rmiiCrsDv       (rmiiCrsDv),
    .rmiiRxd         (rmiiRxd),
    .rxError         (rxError)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] nibOf(input int k, input int seed);
    return 4'((k * 7 + seed * 5 + 3) % 16);
  endfunction

  task automatic driveIdle();
    pcsCarrier      = 1'b0;
    pcsFalseCarrier = 1'b0;
    nibValid        = 1'b0;
    nibData         = 4'h0;
  endtask

  // One nibble every two clocks; carrier dropped on the boundary (late=0) or one clock after (late=1)
  task automatic runFrame(input int m, input int seed, input int late);
    for (int c = 1; c <= 2 * m + 2 * HALF + 2; c++) begin
      int idx;
      int e;
      int expCrs;
      int expRxd;
      @(negedge clk);
      idx        = (c - 1) / 2;
      nibValid   = ((c % 2) == 1) && (idx < m);
      nibData    = nibValid ? nibOf(idx, seed) : 4'h0;
      pcsCarrier = (c <= 2 * m - 1 + late);
      #1;
      e = c - 1;
      if (e == 0) begin
        chk(rmiiCrsDv == 1'b1, "R2", "crsDv on carrier rise", rmiiCrsDv, 1);
        chk(rmiiRxd == 2'b00, "R2", "rxd on carrier rise", rmiiRxd, 0);
      end else if (e < 2 * HALF) begin
        chk(rmiiCrsDv == 1'b1, "R3", "crsDv during fill", rmiiCrsDv, 1);
        chk(rmiiRxd == 2'b00, "R3", "rxd during fill", rmiiRxd, 0);
      end else if (e < 2 * HALF + 2 * m) begin
        int k;
        int ph;
        logic [3:0] n;
        k  = (e - 2 * HALF) / 2;
        ph = (e - 2 * HALF) % 2;
        n  = nibOf(k, seed);
        expRxd = (ph == 1) ? int'(n[3:2]) : int'(n[1:0]);
        expCrs = (e < 2 * m + late) ? 1 : ph;
        chk(rmiiRxd == 2'(expRxd), "R4", "dibit", rmiiRxd, expRxd);
        chk(rmiiCrsDv == 1'(expCrs), "R5", "crsDv in stream/drain", rmiiCrsDv, expCrs);
      end else begin
        chk(rmiiCrsDv == 1'b0, "R1", "crsDv after frame", rmiiCrsDv, 0);
        chk(rmiiRxd == 2'b00, "R1", "rxd after frame", rmiiRxd, 0);
      end
      if (e >= 1)
        chk(rxError == 1'b0, "R9", "error cleared/no error in frame", rxError, 0);
    end
    driveIdle();
  endtask

  task automatic testReset();
    driveIdle();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(rmiiCrsDv == 1'b0, "R1", "crsDv after reset", rmiiCrsDv, 0);
    chk(rmiiRxd == 2'b00, "R1", "rxd after reset", rmiiRxd, 0);
    chk(rxError == 1'b0, "R1", "error after reset", rxError, 0);
  endtask

  task automatic testIgnoredNibbles();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      pcsCarrier = 1'b0;
      nibValid   = 1'b1;
      nibData    = 4'(i + 5);
      #1;
      chk(rmiiCrsDv == 1'b0, "R7", "crsDv with strobes but no carrier", rmiiCrsDv, 0);
      chk(rmiiRxd == 2'b00, "R7", "rxd with strobes but no carrier", rmiiRxd, 0);
    end
    driveIdle();
    // R7: the following frame must show only its own data and fill timing
    runFrame(6, 4, 1);
  endtask

  task automatic testFalseCarrier();
    @(negedge clk);
    pcsCarrier      = 1'b1;
    pcsFalseCarrier = 1'b1;
    nibValid        = 1'b1;
    nibData         = 4'hF;
    #1;
    chk(rmiiCrsDv == 1'b1, "R6", "crsDv at false carrier start", rmiiCrsDv, 1);
    chk(rmiiRxd == 2'b00, "R6", "rxd at false carrier start", rmiiRxd, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pcsFalseCarrier = 1'b0;
      nibValid        = (i % 2) == 0;
      nibData         = 4'(9 + i);
      #1;
      chk(rmiiRxd == 2'b10, "R6", "false carrier code", rmiiRxd, 2);
      chk(rmiiCrsDv == 1'b1, "R6", "crsDv during false carrier", rmiiCrsDv, 1);
    end
    @(negedge clk);
    driveIdle();
    @(negedge clk);
    #1;
    chk(rmiiCrsDv == 1'b0, "R6", "crsDv after false event", rmiiCrsDv, 0);
    chk(rmiiRxd == 2'b00, "R6", "rxd after false event", rmiiRxd, 0);
    // R6: discarded nibbles must not leak into the next frame
    runFrame(5, 5, 0);
  endtask

  task automatic testOverflow();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pcsCarrier = 1'b1;
      nibValid   = 1'b1;
      nibData    = 4'(i);
    end
    @(negedge clk);
    driveIdle();
    repeat (2 * DEPTH + 4) @(negedge clk);
    #1;
    chk(rxError == 1'b1, "R8", "error after overflow", rxError, 1);
    chk(rmiiCrsDv == 1'b0, "R1", "crsDv after overflow frame", rmiiCrsDv, 0);
    chk(rmiiRxd == 2'b00, "R1", "rxd after overflow frame", rmiiRxd, 0);
  endtask

  task automatic testUnderflow();
    for (int i = 0; i < HALF; i++) begin
      @(negedge clk);
      pcsCarrier = 1'b1;
      nibValid   = 1'b1;
      nibData    = 4'(i + 2);
    end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      nibValid = 1'b0;
    end
    #1;
    chk(rxError == 1'b1, "R9", "error on underflow", rxError, 1);
    chk(rmiiRxd == 2'b00, "R9", "rxd while starved", rmiiRxd, 0);
    chk(rmiiCrsDv == 1'b1, "R9", "crsDv while starved", rmiiCrsDv, 1);
    @(negedge clk);
    driveIdle();
    repeat (3) @(negedge clk);
    #1;
    chk(rxError == 1'b1, "R9", "error held after event", rxError, 1);
    chk(rmiiCrsDv == 1'b0, "R1", "crsDv idle after underflow", rmiiCrsDv, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    testReset();
    runFrame(12, 1, 0);
    runFrame(9, 2, 1);
    runFrame(HALF, 3, 0);
    runFrame(HALF, 7, 1);
    testIgnoredNibbles();
    testFalseCarrier();
    testOverflow();
    runFrame(7, 8, 0);
    testUnderflow();
    runFrame(8, 6, 1);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule